// File: doc/BRIEF.md
# Horizontal Scan Slice Expander

This block sits between a narrow group of tester channels and a wider set of parallel scan chains. The tester sends one M-bit word per cycle. The block turns these words into N-bit slices, one bit per chain, and holds each slice in a register that drives the chains. A new slice is built in one of two ways. The first way is cheap: the tester sends a single word, its bits are spread across the slice, and the result is added to the slice already held. The second way is a full reload: N/M words refill the whole slice serially.

A mode bit travels with every word. Shift mode is 1 and add mode is 0. A small controller tracks whether a reload is in progress. It refuses add mode until the register holds a first complete slice. It pulses the chain strobe only when a complete new slice has been committed, so the chains see each slice once and never see a partly loaded one. Back-pressure from the scan side stops the block from accepting tester words.

Top module: `scan_slice_expander`

## Requirements
- R1: While rst_n is low, slice_out is all zeros and scan_en is 0. After reset the controller is idle and holds no valid slice.
- R2: The first word accepted after reset always starts a serial reload, whatever the value of in_mode.
- R3: A serial reload takes G = N/M accepted words. The first word fills slice bits N-1..N-M and each later word fills the next lower M-bit group, so channel j of word k (k = 0 first) lands at slice bit (G-1-k)·M + j. A reload can also be started from the running state by sending a word with in_mode = 1.
- R4: In the middle of a reload, in_mode is ignored, scan_en stays 0 and slice_out does not change. The reloaded slice becomes visible only after the last word.
- R5: In the running state, a word accepted with in_mode = 0 sets the new slice to the old slice plus the sum of in_data[j]·2^(j·G) over all channels j. One word therefore yields one slice.
- R6: scan_en is high for exactly the one cycle after each commit, and slice_out takes its new value in that same cycle. In every other cycle slice_out holds its value.
- R7: in_ready equals scan_ready. A word is taken only on a clock edge where in_valid and scan_ready are both high. When no word is taken, no commit and no state change follow.
- R8: The addition is taken modulo 2^N, so a carry out of bit N-1 is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | A tester word is present |
| in_ready | output | 1 | The block can take a word this cycle |
| in_mode | input | 1 | 1 = shift (reload), 0 = add |
| in_data | input | M | Tester channel word |
| scan_ready | input | 1 | The scan path can accept a slice |
| scan_en | output | 1 | One-cycle strobe for the chains to take slice_out |
| slice_out | output | N | Current slice, one bit per chain |

## Verification
The bench sends add-mode words straight after reset. A design that honoured the mode bit there would emit a strobe that the scoreboard never predicted. The bench also flips in_mode in the middle of a reload, which would make a careless controller commit a half-built slice.

Add controls with several bits set show whether each channel is injected at its spread position. Controls whose carries ripple through empty positions show whether a design is using OR where it should be adding. An all-ones slice plus one tests the wrap: a design with a wider sum would leave stray bits. A long stall with in_valid high tests whether a word leaks past scan_ready low.

// File: rtl/scan_slice_expander_pkg.sv
package scan_slice_expander_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_LOAD = 2'd1,
    ST_RUN  = 2'd2
  } xp_state_e;

  localparam logic MODE_ADD   = 1'b0;
  localparam logic MODE_SHIFT = 1'b1;
endpackage

// File: rtl/ssx_spread.sv
module ssx_spread #(
  parameter int N = 12,
  parameter int M = 4
) (
  input  logic [M-1:0] ctl,
  output logic [N-1:0] inc
);
  localparam int G = N / M;

  for (genvar b = 0; b < N; b++) begin : g_bit
    if (b % G == 0) begin : g_tap
      assign inc[b] = ctl[b / G];
    end else begin : g_zero
      assign inc[b] = 1'b0;
    end
  end
endmodule

// File: rtl/ssx_loader.sv
module ssx_loader #(
  parameter int N = 12,
  parameter int M = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         beat,
  input  logic [M-1:0] word,
  output logic         last_beat,
  output logic [N-1:0] full_slice
);
  localparam int G  = N / M;
  localparam int CW = (G > 1) ? $clog2(G) : 1;
  localparam int PW = N - M;

  logic [CW-1:0] cnt_q, cnt_d;
  logic [PW-1:0] part_q, part_d;

  assign last_beat  = (cnt_q == CW'(G - 1));
  assign full_slice = {part_q, word};

  always_comb begin
    cnt_d = cnt_q;
    if (beat) begin
      cnt_d = last_beat ? '0 : cnt_q + CW'(1);
    end
  end

  if (PW > M) begin : g_wide
    always_comb begin
      part_d = part_q;
      if (beat) part_d = {part_q[PW-M-1:0], word};
    end
  end else begin : g_narrow
    always_comb begin
      part_d = part_q;
      if (beat) part_d = word;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      part_q <= '0;
    end else if (beat) begin
      cnt_q  <= cnt_d;
      part_q <= part_d;
    end
  end
endmodule

// File: rtl/ssx_ctrl.sv
module ssx_ctrl
  import scan_slice_expander_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic acc,
  input  logic mode,
  input  logic last_beat,
  output logic beat,
  output logic commit_add,
  output logic commit_load,
  output logic running
);
  xp_state_e st_q, st_d;

  assign running = (st_q == ST_RUN);

  always_comb begin
    st_d        = st_q;
    beat        = 1'b0;
    commit_add  = 1'b0;
    commit_load = 1'b0;
    unique case (st_q)
      ST_IDLE, ST_LOAD: begin
        if (acc) begin
          beat = 1'b1;
          if (last_beat) begin
            commit_load = 1'b1;
            st_d        = ST_RUN;
          end else begin
            st_d = ST_LOAD;
          end
        end
      end
      ST_RUN: begin
        if (acc) begin
          if (mode == MODE_ADD) begin
            commit_add = 1'b1;
          end else begin
            beat = 1'b1;
            if (last_beat) commit_load = 1'b1;
            else           st_d = ST_LOAD;
          end
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= ST_IDLE;
    else        st_q <= st_d;
  end
endmodule

// File: rtl/scan_slice_expander.sv
module scan_slice_expander #(
  parameter int N_CHAINS = 12,
  parameter int N_CHAN   = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                in_valid,
  output logic                in_ready,
  input  logic                in_mode,
  input  logic [N_CHAN-1:0]   in_data,
  input  logic                scan_ready,
  output logic                scan_en,
  output logic [N_CHAINS-1:0] slice_out
);
  localparam int N = N_CHAINS;
  localparam int M = N_CHAN;

  logic         acc, beat, commit_add, commit_load, last_beat, ctrl_running;
  logic [N-1:0] inc, full_slice;
  logic [N-1:0] slice_q, slice_d;
  logic         se_q, se_d;

  assign in_ready = scan_ready;
  assign acc      = in_valid & scan_ready;

  ssx_spread #(.N(N), .M(M)) u_spread (
    .ctl (in_data),
    .inc (inc)
  );

  ssx_loader #(.N(N), .M(M)) u_loader (
    .clk        (clk),
    .rst_n      (rst_n),
    .beat       (beat),
    .word       (in_data),
    .last_beat  (last_beat),
    .full_slice (full_slice)
  );

  ssx_ctrl u_ctrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .acc         (acc),
    .mode        (in_mode),
    .last_beat   (last_beat),
    .beat        (beat),
    .commit_add  (commit_add),
    .commit_load (commit_load),
    .running     (ctrl_running)
  );

  always_comb begin
    slice_d = slice_q;
    if (commit_add)       slice_d = slice_q + inc;
    else if (commit_load) slice_d = full_slice;
    se_d = commit_add | commit_load;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      slice_q <= '0;
      se_q    <= 1'b0;
    end else begin
      se_q <= se_d;
      if (se_d) slice_q <= slice_d;
    end
  end

  assign scan_en   = se_q;
  assign slice_out = slice_q;
endmodule

// File: rtl/scan_slice_expander_chk.sv
module scan_slice_expander_chk #(
  parameter int N = 12,
  parameter int M = 4
) (
  input logic         clk,
  input logic         rst_n,
  input logic         in_valid,
  input logic         in_ready,
  input logic         in_mode,
  input logic [M-1:0] in_data,
  input logic         scan_ready,
  input logic         scan_en,
  input logic [N-1:0] slice_out,
  input logic         running
);
  localparam int G = N / M;
  logic [N-1:0] exp_inc;

  always_comb begin
    exp_inc = '0;
    for (int j = 0; j < M; j++) exp_inc[j*G] = in_data[j];
  end

  p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !scan_en |-> $stable(slice_out));

  p_ready_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !scan_ready |-> !in_ready);

  p_no_take_no_commit_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !(in_valid && in_ready) |=> !scan_en);

  p_add_sum_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && running && !in_mode) |=>
      (scan_en && slice_out == $past(slice_out) + $past(exp_inc)));

  always @(posedge clk) begin
    if (!rst_n) begin
      p_reset_r1: assert (!scan_en && slice_out == '0);
    end
  end
endmodule

bind scan_slice_expander scan_slice_expander_chk #(.N(N_CHAINS), .M(N_CHAN)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .in_valid   (in_valid),
  .in_ready   (in_ready),
  .in_mode    (in_mode),
  .in_data    (in_data),
  .scan_ready (scan_ready),
  .scan_en    (scan_en),
  .slice_out  (slice_out),
  .running    (ctrl_running)
);

// File: tb/scan_slice_expander_tb.sv
module scan_slice_expander_tb;
  localparam int N = 12;
  localparam int M = 4;
  localparam int G = N / M;
  localparam time CLK_PERIOD = 10ns;

  logic clk, rst_n, in_valid, in_ready, in_mode, scan_ready, scan_en;
  logic [M-1:0] in_data;
  logic [N-1:0] slice_out;

  int checks = 0;
  int failures = 0;
  logic [N-1:0] exp_q[$];
  logic [N-1:0] held;
  logic [N-1:0] ref_sl, acc_sl;
  bit started = 0, loading = 0;
  int nbeat = 0;
  int commits_seen = 0, commits_exp = 0;

  scan_slice_expander #(.N_CHAINS(N), .N_CHAN(M)) u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_mode(in_mode), .in_data(in_data), .scan_ready(scan_ready),
    .scan_en(scan_en), .slice_out(slice_out)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input bit ok, input string req, input logic [N-1:0] act, input logic [N-1:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [N-1:0] spread(input logic [M-1:0] w);
    logic [N-1:0] r = '0;
    for (int j = 0; j < M; j++) if (w[j]) r = r + (N'(1) << (j*G));
    return r;
  endfunction

  // Driver: hands one word over, then updates the reference model.
  task automatic send(input logic [M-1:0] w, input logic m);
    @(negedge clk);
    in_valid = 1'b1; in_data = w; in_mode = m;
    while (!in_ready) @(negedge clk);
    @(posedge clk);
    if (started && !loading && m == 1'b0) begin
      ref_sl = ref_sl + spread(w);
      exp_q.push_back(ref_sl); commits_exp++;
    end else begin
      acc_sl = {acc_sl[N-M-1:0], w};
      loading = 1; nbeat++;
      if (nbeat == G) begin
        ref_sl = acc_sl; exp_q.push_back(ref_sl); commits_exp++;
        nbeat = 0; loading = 0; started = 1;
      end
    end
  endtask

  task automatic idle(input int n);
    @(negedge clk); in_valid = 1'b0;
    repeat (n) @(negedge clk);
  endtask

  // Monitor: compares each strobed slice against the scoreboard.
  always @(negedge clk) begin
    if (rst_n) begin
      if (scan_en) begin
        commits_seen++;
        if (exp_q.size() == 0) chk(1'b0, "R4 unexpected strobe", slice_out, held);
        else begin
          logic [N-1:0] e;
          e = exp_q.pop_front();
          chk(slice_out == e, "R5/R3 committed slice", slice_out, e);
        end
        held = slice_out;
      end else begin
        chk(slice_out == held, "R6 slice held without strobe", slice_out, held);
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    rst_n = 1'b0; in_valid = 1'b0; in_mode = 1'b0; in_data = '0; scan_ready = 1'b1;
    held = '0; ref_sl = '0; acc_sl = '0;
    repeat (3) @(negedge clk);
    chk(slice_out == '0 && !scan_en, "R1 reset state", slice_out, '0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(slice_out == '0 && !scan_en, "R1 idle after reset", slice_out, '0);

    // R2: add-mode first word still starts a reload; R4: mode flip mid-load ignored
    send(4'hA, 1'b0);
    send(4'h5, 1'b1);
    send(4'h3, 1'b0);
    idle(2);
    chk(slice_out == 12'hA53, "R2 R3 first reload", slice_out, 12'hA53);

    // R5: add 0011 -> +9, 1111 -> +585, 0100 -> +64
    send(4'b0011, 1'b0);
    send(4'b1111, 1'b0);
    send(4'b0100, 1'b0);
    idle(2);
    chk(slice_out == 12'hA53 + 12'd9 + 12'd585 + 12'd64, "R5 add sequence",
        slice_out, 12'hA53 + 12'd9 + 12'd585 + 12'd64);

    // R3 reload from running, then R8 wrap
    send(4'hF, 1'b1);
    idle(3);
    chk(slice_out == 12'hA53 + 12'd658, "R4 no change mid-load", slice_out, 12'hA53 + 12'd658);
    send(4'hF, 1'b1);
    send(4'hF, 1'b0);
    send(4'b0001, 1'b0);
    idle(2);
    chk(slice_out == 12'h000, "R8 wrap to zero", slice_out, 12'h000);

    // R7: stall with a word waiting
    @(negedge clk);
    scan_ready = 1'b0; in_valid = 1'b1; in_data = 4'b1000; in_mode = 1'b0;
    repeat (4) begin
      @(negedge clk);
      chk(!in_ready && !scan_en, "R7 stalled", {11'd0, in_ready}, '0);
    end
    chk(slice_out == 12'h000, "R7 no take while stalled", slice_out, 12'h000);
    in_valid = 1'b0; scan_ready = 1'b1;
    send(4'b1000, 1'b0);
    send(4'b0110, 1'b0);
    idle(2);
    chk(slice_out == 12'd512 + 12'd72, "R5 after stall", slice_out, 12'd584);

    idle(3);
    chk(exp_q.size() == 0, "R6 all commits strobed", N'(exp_q.size()), '0);
    chk(commits_seen == commits_exp, "R6 strobe count", N'(commits_seen), N'(commits_exp));
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule